// File: doc/BRIEF.md
# USB Host Controller Interrupt Aggregator

This block collects the event pulses of a USB host controller into sticky status bits and turns them into one level-sensitive interrupt line. Each event source (scheduling overrun, done-queue writeback, frame start, resume detected, fatal error, frame counter wrap, root port change, handover request) pulses its input for one cycle. The matching status bit then stays set until software clears it.

Software reaches the block through a small 32-bit register port with four address codes. Code 0 is the status register, which is cleared by writing ones. Code 1 sets enable bits by writing ones. Code 2 clears enable bits by writing ones. Code 3 is an unused spare. Reads of codes 1 and 2 both return the same single enable register. Its top bit is a master gate that covers every source at once.

The output line comes from a two-state machine. The state `LINE_QUIET` drives the line low and `LINE_RAISED` drives it high. The transition `RAISE` (QUIET to RAISED) is taken at the clock edge after the pending condition becomes true. The transition `DROP` (RAISED to QUIET) is taken at the clock edge after the condition becomes false. The pending condition is true when the master gate is set and at least one status bit is also enabled.

Top module: `hci_irq_agg`

## Requirements
- R1: An event pulse on input `evt_i[k]` sets a status bit at the next clock edge. For k = 0..6 the bit is k. For k = 7 the bit is 30. The bit stays set (sticky) until software clears it.
- R2: A write to address code 0 clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R3: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit is set after the edge.
- R4: A write to address code 1 ORs the write data into all 32 bits of the enable register.
- R5: A write to address code 2 clears every enable bit written as 1 and leaves the other enable bits unchanged.
- R6: Read data is combinational. Code 0 returns the status register. Codes 1 and 2 both return the enable register. Code 3 reads zero, and a write to code 3 changes no register.
- R7: After reset the status register reads 0x00000000, the enable register reads 0x80000000 (master gate only) and `irq_o` is low.
- R8: `irq_o` is high only when enable bit 31 is set and the AND of status and enable is nonzero.
- R9: `irq_o` is registered. It reflects the status and enable contents of the previous cycle, so it changes one clock after the change that caused it.
- R10: Status bit positions with no event source (7..29 and 31) always read 0, and clearing them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_EVT (8) | One-cycle event pulses, index order as in R1 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address code |
| reg_wdata_i | input | REG_W (32) | Write data |
| reg_rdata_o | output | REG_W (32) | Read data for `reg_addr_i` |
| irq_o | output | 1 | Level-sensitive interrupt request |

## Verification
The bench builds the block with its default parameters: eight event sources and a 32-bit register width. With these values the sparse mapping is reachable, where the last source lands on bit 30 next to the master gate in bit 31. The bench compares a behavioural reference model against the read data and the interrupt line on every clock.

The directed steps cover the following cases:
- the one-cycle lag of the line;
- an event colliding with a clearing write on the same bit;
- master-gate removal and restoration;
- spare-address writes;
- clears aimed at unpopulated status bits.

A pseudo-random phase then mixes events, writes and reads across all address codes.

// File: rtl/hci_irq_pkg.sv
package hci_irq_pkg;

    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 2'd0,
        REG_EN_SET = 2'd1,
        REG_EN_CLR = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;

    // Event index to status bit position: the last source sits just below
    // the master-gate bit, the others fill the low bits in order.
    function automatic int unsigned evt_pos(input int unsigned idx,
                                            input int unsigned n_evt,
                                            input int unsigned reg_w);
        return (idx == n_evt - 1) ? (reg_w - 2) : idx;
    endfunction

endpackage

// File: rtl/hci_irq_status.sv
module hci_irq_status
    import hci_irq_pkg::*;
#(
    parameter int unsigned REG_W   = 32,
    parameter int unsigned NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               clr_en_i,
    input  logic [REG_W-1:0]   clr_mask_i,
    output logic [REG_W-1:0]   status_o
);

    function automatic logic [REG_W-1:0] build_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_EVT; k++) begin
            m[evt_pos(k, NUM_EVT, REG_W)] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [REG_W-1:0] IMPL_MASK = build_mask();

    logic [REG_W-1:0] status_q;
    logic [REG_W-1:0] status_d;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;

    always_comb begin
        set_vec = '0;
        for (int k = 0; k < NUM_EVT; k++) begin
            set_vec[evt_pos(k, NUM_EVT, REG_W)] = evt_i[k];
        end
    end

    assign clr_vec  = clr_en_i ? clr_mask_i : '0;
    // set term applied after the clear term: a colliding event wins
    assign status_d = ((status_q & ~clr_vec) | set_vec) & IMPL_MASK;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    assign status_o = status_q;

    AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec))); // R1 R3

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && set_vec == '0) |=> ((status_q & $past(clr_mask_i)) == '0)); // R2

    AST_W1C_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((status_q & $past(status_q) & ~$past(clr_mask_i))
                      == ($past(status_q) & ~$past(clr_mask_i)))); // R2

    AST_UNPOPULATED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((status_q & ~$past(set_vec) & ~$past(status_q)) == '0)); // R10

endmodule

// File: rtl/hci_irq_enable.sv
module hci_irq_enable #(
    parameter int unsigned REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en_i,
    input  logic             clr_en_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] en_o
);

    localparam int unsigned      MASTER_BIT = REG_W - 1;
    localparam logic [REG_W-1:0] EN_RESET   = {1'b1, {(REG_W-1){1'b0}}};

    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] en_d;

    always_comb begin
        en_d = en_q;
        if (set_en_i) begin
            en_d = en_q | wdata_i;
        end else if (clr_en_i) begin
            en_d = en_q & ~wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= EN_RESET;
        end else begin
            en_q <= en_d;
        end
    end

    assign en_o = en_q;

    AST_EN_OR_IN: assert property (@(posedge clk) disable iff (!rst_n)
        set_en_i |=> ((en_q & $past(wdata_i)) == $past(wdata_i))); // R4

    AST_EN_KEEP_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_en_i |=> ((en_q & $past(en_q)) == $past(en_q))); // R4

    AST_EN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((en_q & $past(wdata_i)) == '0)); // R5

    AST_EN_NO_GROW_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((en_q & ~$past(en_q)) == '0)); // R5

    AST_MASTER_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en_i && !clr_en_i) |=> (en_q[MASTER_BIT] == $past(en_q[MASTER_BIT]))); // R6

endmodule

// File: rtl/hci_irq_line.sv
module hci_irq_line
    import hci_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    output logic irq_o
);

    line_state_e state_q;
    line_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LINE_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET:  if (pending_i)  state_d = LINE_RAISED; // RAISE
            LINE_RAISED: if (!pending_i) state_d = LINE_QUIET;  // DROP
            default:                     state_d = LINE_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == LINE_RAISED);
    end

    AST_RISE_AFTER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(pending_i)); // R9

    AST_FALL_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> !$past(pending_i)); // R9

endmodule

// File: rtl/hci_irq_agg.sv
module hci_irq_agg
    import hci_irq_pkg::*;
#(
    parameter int unsigned REG_W   = 32,
    parameter int unsigned NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [REG_W-1:0]   reg_wdata_i,
    output logic [REG_W-1:0]   reg_rdata_o,
    output logic               irq_o
);

    localparam int unsigned MASTER_BIT = REG_W - 1;

    reg_sel_e         sel;
    logic             wr_status;
    logic             wr_en_set;
    logic             wr_en_clr;
    logic [REG_W-1:0] status_q;
    logic [REG_W-1:0] en_q;
    logic             pending;

    assign sel       = reg_sel_e'(reg_addr_i);
    assign wr_status = reg_wr_i && (sel == REG_STATUS);
    assign wr_en_set = reg_wr_i && (sel == REG_EN_SET);
    assign wr_en_clr = reg_wr_i && (sel == REG_EN_CLR);

    hci_irq_status #(
        .REG_W   (REG_W),
        .NUM_EVT (NUM_EVT)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .clr_en_i   (wr_status),
        .clr_mask_i (reg_wdata_i),
        .status_o   (status_q)
    );

    hci_irq_enable #(
        .REG_W (REG_W)
    ) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en_i (wr_en_set),
        .clr_en_i (wr_en_clr),
        .wdata_i  (reg_wdata_i),
        .en_o     (en_q)
    );

    assign pending = en_q[MASTER_BIT] && ((status_q & en_q) != '0);

    hci_irq_line u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .irq_o     (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        unique case (sel)
            REG_STATUS: reg_rdata_o = status_q;
            REG_EN_SET: reg_rdata_o = en_q;
            REG_EN_CLR: reg_rdata_o = en_q;
            REG_SPARE:  reg_rdata_o = '0;
            default:    reg_rdata_o = '0;
        endcase
    end

    AST_MASTER_GATES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[MASTER_BIT] |=> !irq_o); // R8

    AST_NO_CAUSE_NO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & en_q) == '0) |=> !irq_o); // R8

    AST_SPARE_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && sel == REG_SPARE) |=> (en_q == $past(en_q))); // R6

endmodule

// File: tb/test_hci_irq_agg.sv
module test_hci_irq_agg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt = '0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [31:0] m_stat;
    logic [31:0] m_en;
    logic        m_irq;

    always #10 clk = ~clk;

    hci_irq_agg i_hci_irq_agg (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    function automatic logic [31:0] evt_to_bits(input logic [7:0] e);
        logic [31:0] b;
        b = {24'b0, 1'b0, e[6:0]};
        b[30] = e[7];
        return b;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat = 32'h0;
            m_en   = 32'h8000_0000;
            m_irq  = 1'b0;
        end else begin
            m_irq = m_en[31] && ((m_stat & m_en) != 0);
            if (wr && addr == 2'd0) m_stat = m_stat & ~wdata;
            m_stat = (m_stat | evt_to_bits(evt)) & 32'h4000_007F;
            if (wr && addr == 2'd1) m_en = m_en | wdata;
            if (wr && addr == 2'd2) m_en = m_en & ~wdata;
        end
    end

    function automatic logic [31:0] exp_read();
        case (addr)
            2'd0:    return m_stat;
            2'd1:    return m_en;
            2'd2:    return m_en;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // compare at the falling edge, then drive the next cycle's inputs
    task automatic step(input string tag, input logic [7:0] e,
                        input logic w, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        chk(tag, "rdata", rdata, exp_read());
        chk("R8 R9", "irq", {31'b0, irq}, {31'b0, m_irq});
        evt = e; wr = w; addr = a; wdata = d;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        addr = 2'd1;
        #1;
        chk("R7", "enable after reset", rdata, 32'h8000_0000);
        chk("R7", "irq after reset", {31'b0, irq}, 32'h0);
        addr = 2'd0;
        #1;
        chk("R7", "status after reset", rdata, 32'h0);
        rst_n = 1'b1;

        // R1: each source alone, sticky
        for (int k = 0; k < 8; k++) begin
            step("R1", 8'(1 << k), 1'b0, 2'd0, 32'h0);
        end
        step("R1", 8'h00, 1'b0, 2'd0, 32'h0);
        step("R1", 8'h00, 1'b0, 2'd0, 32'h0);
        chk("R1", "all sticky", rdata, 32'h4000_007F);
        // R2: partial clear
        step("R2", 8'h00, 1'b1, 2'd0, 32'h0000_0005);
        step("R2", 8'h00, 1'b0, 2'd0, 32'h0);
        step("R2", 8'h00, 1'b0, 2'd0, 32'h0);
        chk("R2", "partial clear", rdata, 32'h4000_007A);
        // R3: collision on bit 2
        step("R3", 8'h04, 1'b1, 2'd0, 32'h0000_0004);
        step("R3", 8'h00, 1'b0, 2'd0, 32'h0);
        step("R3", 8'h00, 1'b0, 2'd0, 32'h0);
        chk("R3", "event wins", rdata & 32'h4, 32'h4);
        // R10: clearing unpopulated bits
        step("R10", 8'h00, 1'b1, 2'd0, 32'hBFFF_FF80);
        step("R10", 8'h00, 1'b0, 2'd0, 32'h0);
        step("R10", 8'h00, 1'b0, 2'd0, 32'h0);
        chk("R10", "unpopulated", rdata, 32'h4000_007E);
        // R4 and R9: enable bit 2, line one clock later
        step("R4", 8'h00, 1'b1, 2'd1, 32'h0000_0004);
        step("R4", 8'h00, 1'b0, 2'd1, 32'h0);
        chk("R9", "line lags", {31'b0, irq}, 32'h0);
        step("R4", 8'h00, 1'b0, 2'd2, 32'h0);
        chk("R6", "disable alias read", rdata, 32'h8000_0004);
        chk("R9", "line raised", {31'b0, irq}, 32'h1);
        // R8: remove master gate
        step("R8", 8'h00, 1'b1, 2'd2, 32'h8000_0000);
        step("R8", 8'h00, 1'b0, 2'd1, 32'h0);
        step("R8", 8'h00, 1'b0, 2'd1, 32'h0);
        chk("R8", "master off", {31'b0, irq}, 32'h0);
        step("R8", 8'h00, 1'b1, 2'd1, 32'h8000_0000);
        step("R5", 8'h00, 1'b0, 2'd1, 32'h0);
        step("R5", 8'h00, 1'b1, 2'd2, 32'h0000_0004);
        step("R5", 8'h00, 1'b0, 2'd1, 32'h0);
        step("R5", 8'h00, 1'b0, 2'd1, 32'h0);
        chk("R5", "enable cleared", rdata, 32'h8000_0000);
        // R6: spare address
        step("R6", 8'h00, 1'b1, 2'd3, 32'hFFFF_FFFF);
        step("R6", 8'h00, 1'b0, 2'd3, 32'h0);
        chk("R6", "spare reads zero", rdata, 32'h0);
        step("R6", 8'h00, 1'b0, 2'd1, 32'h0);
        step("R6", 8'h00, 1'b0, 2'd1, 32'h0);
        chk("R6", "spare write inert", rdata, 32'h8000_0000);

        // mixed traffic
        begin
            logic [31:0] lfsr;
            lfsr = 32'hACE1_2345;
            for (int n = 0; n < 400; n++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                step("R1 R2 R4 R5 R6 mixed",
                     (lfsr[3:0] == 4'h0) ? lfsr[15:8] : 8'h00,
                     lfsr[4] & lfsr[5],
                     lfsr[7:6],
                     {lfsr[31], lfsr[16], lfsr[29:0]} ^ {lfsr[0], 31'h0});
            end
        end
        step("R8", 8'h00, 1'b0, 2'd0, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule